// File: doc/BRIEF.md
# Transmit Mailbox Abort Controller

This block handles software requests to cancel a frame queued in one of a set of transmit mailboxes, and it reports how each such frame ended. Each mailbox holds a 4-bit code that software writes through a simple write port (mailbox index plus code). The transmit engine tells the block which mailbox it has copied into the serial shift buffer. It then pulses one of three events for that mailbox: arbitration lost, frame sent, or transmit error.

A cancel request works only while the abort-enable input is high. A cancel aimed at a mailbox still waiting in the queue takes effect at once. A cancel aimed at the mailbox that sits in the shift buffer or is on the bus is held back, and the mailbox stays active. The request is latched and resolved by the next bus event: a lost arbitration or an error turns it into a cancelled frame, and a successful send drops it. Every outcome raises the mailbox's interrupt flag. It is also announced by a one-cycle result pulse carrying the mailbox index and a bit that says whether the frame was cancelled or sent.

Top module: `tx_abort_ctrl`

## Requirements
- R1: While `abort_en` is low, a write stores its code into the addressed mailbox unchanged and clears that mailbox's flag, even when the mailbox sits in the shift buffer.
- R2: Code values: 4'b1100 = transmit requested, 4'b1001 = cancelled (and the cancel request code), 4'b1000 = inactive. After reset every mailbox code is 4'b1000, every flag is 0 and `res_valid` is 0.
- R3: With `abort_en` high, writing 4'b1001 to a mailbox whose code is 4'b1100 and that is not in the shift buffer sets its code to 4'b1001 and its flag to 1, and reports a result with `res_aborted`=1.
- R4: With `abort_en` high, writing 4'b1001 to the mailbox in the shift buffer leaves its code unchanged and latches a pending cancel.
- R5: An arbitration loss for a mailbox with a pending cancel, including one written in the same cycle, sets its code to 4'b1001 and its flag, and reports `res_aborted`=1.
- R6: A transmit error for a mailbox with a pending cancel has the same effect as R5.
- R7: A successful send sets the code to 4'b1000 and the flag, drops any pending cancel, and reports `res_aborted`=0.
- R8: An arbitration loss or error without a pending cancel frees the shift buffer, leaves the code at 4'b1100, and reports nothing.
- R9: With `abort_en` high, a non-cancel write to an active mailbox (code 4'b1100 or in the shift buffer) is ignored; to any other mailbox it is stored and clears the flag.
- R10: With `abort_en` high, writing 4'b1001 to a mailbox that is not active has no effect.
- R11: A result appears in the cycle after the edge that decides the outcome. At most one result is given per cycle; when outcomes collide, the lowest mailbox index is reported first and the rest follow in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| abort_en | input | 1 | Enables the cancel mechanism |
| wr_valid | input | 1 | Code write strobe |
| wr_mb | input | 3 | Mailbox index of the write |
| wr_code | input | 4 | Code written |
| load_valid | input | 1 | Engine copied a mailbox into the shift buffer |
| load_mb | input | 3 | Index of that mailbox |
| arb_lost | input | 1 | Shift-buffer frame lost arbitration |
| tx_done | input | 1 | Shift-buffer frame sent |
| tx_err | input | 1 | Shift-buffer frame ended with an error |
| mb_code | output | 32 | Current codes, mailbox i at bits 4i+3:4i |
| mb_flag | output | 8 | Per-mailbox interrupt flags |
| res_valid | output | 1 | One-cycle result pulse |
| res_mb | output | 3 | Mailbox index of the result |
| res_aborted | output | 1 | 1 = cancelled, 0 = sent |

## Verification
Cancels are sent to mailboxes in each of three conditions: queued, in the shift buffer, and idle. This separates the immediate path, the blocked-and-latched path, and the ignored case. Each latched cancel is then resolved by a different bus event (arbitration loss, error, successful send), so that a wrong outcome for any one event shows up as a wrong code or result bit. The same writes are repeated with the enable low to show the plain-write behaviour. A collision of two outcomes in one cycle, and a cancel arriving together with an arbitration loss, exercise the result ordering and the same-cycle merge.

// File: rtl/tx_abort_pkg.sv
package tx_abort_pkg;
   localparam int CODE_W = 4;
   typedef logic [CODE_W-1:0] mb_code_t;
   localparam mb_code_t CODE_INACTIVE = 4'b1000;
   localparam mb_code_t CODE_ABORT    = 4'b1001;
   localparam mb_code_t CODE_TXREQ    = 4'b1100;
endpackage

// File: rtl/tx_abort_slot.sv
// Tracks the single mailbox held in the shift buffer and its latched cancel.
module tx_abort_slot #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_idx,
   input  logic             arb_lost,
   input  logic             tx_done,
   input  logic             tx_err,
   input  logic             abort_wr,
   input  logic [IDX_W-1:0] abort_idx,
   output logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic             ev_abort,
   output logic             ev_sent
);
   logic req;
   logic abort_hit;
   logic ev_end;

   assign abort_hit = abort_wr && busy && (abort_idx == idx);
   assign ev_end    = busy && (arb_lost || tx_err || tx_done);
   assign ev_sent   = busy && tx_done;
   assign ev_abort  = busy && (arb_lost || tx_err) && (req || abort_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         req  <= 1'b0;
      end else if (load) begin
         busy <= 1'b1;
         idx  <= load_idx;
         req  <= 1'b0;
      end else if (ev_end) begin
         busy <= 1'b0;
         req  <= 1'b0;
      end else if (abort_hit) begin
         req  <= 1'b1;
      end
   end

   // R8: bus events refer to an occupied shift buffer
   a_r8_event_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost || tx_done || tx_err) |-> busy);
   // R7: at most one bus event per cycle
   a_r7_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({arb_lost, tx_done, tx_err}));
   // R4: a blocked cancel stays latched until the slot resolves
   a_r4_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_hit && !ev_end && !load) |=> (req && busy));
   // loading only into a free (or freeing) shift buffer
   a_r11_load_free: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!busy || ev_end));
endmodule

// File: rtl/tx_abort_mailbox.sv
// One transmit mailbox: code, interrupt flag and pending result.
module tx_abort_mailbox
   import tx_abort_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     abort_en,
   input  logic     wr_hit,
   input  mb_code_t wr_code,
   input  logic     in_slot,
   input  logic     outcome_abort,
   input  logic     outcome_sent,
   input  logic     rpt_ack,
   output mb_code_t code,
   output logic     flag,
   output logic     rpt_pend,
   output logic     rpt_kind
);
   mb_code_t code_d;
   logic     flag_d;
   logic     kind_d;
   logic     set_rpt;
   logic     active;
   logic     is_abort;

   assign active   = in_slot || (code == CODE_TXREQ);
   assign is_abort = (wr_code == CODE_ABORT);

   always_comb begin
      code_d  = code;
      flag_d  = flag;
      kind_d  = rpt_kind;
      set_rpt = 1'b0;
      if (outcome_abort) begin
         code_d  = CODE_ABORT;
         flag_d  = 1'b1;
         kind_d  = 1'b1;
         set_rpt = 1'b1;
      end else if (outcome_sent) begin
         code_d  = CODE_INACTIVE;
         flag_d  = 1'b1;
         kind_d  = 1'b0;
         set_rpt = 1'b1;
      end else if (wr_hit) begin
         if (!abort_en) begin
            code_d = wr_code;
            flag_d = 1'b0;
         end else if (is_abort) begin
            if (!in_slot && code == CODE_TXREQ) begin
               code_d  = CODE_ABORT;
               flag_d  = 1'b1;
               kind_d  = 1'b1;
               set_rpt = 1'b1;
            end
         end else if (!active) begin
            code_d = wr_code;
            flag_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code     <= CODE_INACTIVE;
         flag     <= 1'b0;
         rpt_pend <= 1'b0;
         rpt_kind <= 1'b0;
      end else begin
         code     <= code_d;
         flag     <= flag_d;
         rpt_kind <= kind_d;
         rpt_pend <= set_rpt || (rpt_pend && !rpt_ack);
      end
   end

   // R1: with the mechanism off, writes land as written
   a_r1_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!abort_en && wr_hit && !outcome_abort && !outcome_sent) |=> (code == $past(wr_code)));
   // R3: a queued mailbox is cancelled at once
   a_r3_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_en && wr_hit && is_abort && !in_slot && code == CODE_TXREQ)
      |=> (code == CODE_ABORT && flag && rpt_pend));
   // R4: a cancel into the shift-buffer mailbox does not change its code
   a_r4_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_en && wr_hit && is_abort && in_slot && !outcome_abort && !outcome_sent)
      |=> $stable(code));
   // R7: a sent frame leaves the mailbox inactive with a result queued
   a_r7_sent: assert property (@(posedge clk) disable iff (!rst_n)
      outcome_sent |=> (code == CODE_INACTIVE && flag && rpt_pend && !rpt_kind));
endmodule

// File: rtl/tx_abort_report.sv
// Serialises per-mailbox results onto one result port.
module tx_abort_report #(
   parameter int NUM_MB    = 8,
   parameter int IDX_W     = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [NUM_MB-1:0] pend,
   input  logic [NUM_MB-1:0] kind,
   output logic              valid,
   output logic [IDX_W-1:0]  idx,
   output logic              aborted,
   output logic [NUM_MB-1:0] ack
);
   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = NUM_MB - 1; i >= 0; i--)
               if (pend[i]) idx = IDX_W'(i);
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < NUM_MB; i++)
               if (pend[i]) idx = IDX_W'(i);
         end
      end
   endgenerate

   assign valid   = |pend;
   assign aborted = kind[idx];

   always_comb begin
      ack = '0;
      if (valid) ack[idx] = 1'b1;
   end
endmodule

// File: rtl/tx_abort_ctrl.sv
module tx_abort_ctrl
   import tx_abort_pkg::*;
#(
   parameter  int NUM_MB    = 8,
   parameter  bit LOW_FIRST = 1'b1,
   localparam int IDX_W     = $clog2(NUM_MB)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     abort_en,
   input  logic                     wr_valid,
   input  logic [IDX_W-1:0]         wr_mb,
   input  logic [CODE_W-1:0]        wr_code,
   input  logic                     load_valid,
   input  logic [IDX_W-1:0]         load_mb,
   input  logic                     arb_lost,
   input  logic                     tx_done,
   input  logic                     tx_err,
   output logic [NUM_MB*CODE_W-1:0] mb_code,
   output logic [NUM_MB-1:0]        mb_flag,
   output logic                     res_valid,
   output logic [IDX_W-1:0]         res_mb,
   output logic                     res_aborted
);
   generate
      if (NUM_MB < 2 || NUM_MB > 64 || (1 << IDX_W) != NUM_MB) begin : g_bad_num
         $error("tx_abort_ctrl: NUM_MB must be a power of two in 2..64");
      end
   endgenerate

   logic             slot_busy;
   logic [IDX_W-1:0] slot_idx;
   logic             ev_abort;
   logic             ev_sent;
   logic             abort_wr;
   logic [NUM_MB-1:0] pend;
   logic [NUM_MB-1:0] kind;
   logic [NUM_MB-1:0] ack;

   assign abort_wr = wr_valid && abort_en && (wr_code == CODE_ABORT);

   tx_abort_slot #(.IDX_W(IDX_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_valid),
      .load_idx  (load_mb),
      .arb_lost  (arb_lost),
      .tx_done   (tx_done),
      .tx_err    (tx_err),
      .abort_wr  (abort_wr),
      .abort_idx (wr_mb),
      .busy      (slot_busy),
      .idx       (slot_idx),
      .ev_abort  (ev_abort),
      .ev_sent   (ev_sent)
   );

   for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
      logic sel;
      assign sel = slot_busy && (slot_idx == IDX_W'(i));
      tx_abort_mailbox u_mb (
         .clk           (clk),
         .rst_n         (rst_n),
         .abort_en      (abort_en),
         .wr_hit        (wr_valid && (wr_mb == IDX_W'(i))),
         .wr_code       (wr_code),
         .in_slot       (sel),
         .outcome_abort (sel && ev_abort),
         .outcome_sent  (sel && ev_sent),
         .rpt_ack       (ack[i]),
         .code          (mb_code[i*CODE_W +: CODE_W]),
         .flag          (mb_flag[i]),
         .rpt_pend      (pend[i]),
         .rpt_kind      (kind[i])
      );
   end

   tx_abort_report #(.NUM_MB(NUM_MB), .IDX_W(IDX_W), .LOW_FIRST(LOW_FIRST)) u_rpt (
      .pend    (pend),
      .kind    (kind),
      .valid   (res_valid),
      .idx     (res_mb),
      .aborted (res_aborted),
      .ack     (ack)
   );

   // R11: a reported result is removed in the next cycle
   a_r11_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !(slot_busy && slot_idx == res_mb)
       && !(wr_valid && wr_mb == res_mb))
      |=> !pend[$past(res_mb)]);
   // R5: an arbitration loss with a latched cancel yields a cancelled code
   a_r5_arb_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_abort && arb_lost) |=> (mb_code[$past(slot_idx)*CODE_W +: CODE_W] == CODE_ABORT));
endmodule

// File: tb/tx_abort_ctrl_test.sv
module tx_abort_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        abort_en = 1'b1;
   logic        wr_valid = 1'b0;
   logic [2:0]  wr_mb = '0;
   logic [3:0]  wr_code = '0;
   logic        load_valid = 1'b0;
   logic [2:0]  load_mb = '0;
   logic        arb_lost = 1'b0;
   logic        tx_done = 1'b0;
   logic        tx_err = 1'b0;
   logic [31:0] mb_code;
   logic [7:0]  mb_flag;
   logic        res_valid;
   logic [2:0]  res_mb;
   logic        res_aborted;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   tx_abort_ctrl uut (
      .clk(clk), .rst_n(rst_n), .abort_en(abort_en),
      .wr_valid(wr_valid), .wr_mb(wr_mb), .wr_code(wr_code),
      .load_valid(load_valid), .load_mb(load_mb),
      .arb_lost(arb_lost), .tx_done(tx_done), .tx_err(tx_err),
      .mb_code(mb_code), .mb_flag(mb_flag),
      .res_valid(res_valid), .res_mb(res_mb), .res_aborted(res_aborted)
   );

   localparam logic [2:0] OP_WR = 3'd0, OP_LD = 3'd1, OP_ARB = 3'd2, OP_DONE = 3'd3, OP_ERR = 3'd4;
   localparam logic [1:0] RS_NONE = 2'd0, RS_SENT = 2'd1, RS_ABRT = 2'd2;
   // {req[3:0], en, op[2:0], mb[2:0], code[3:0], exp_code[3:0], exp_res[1:0]}
   localparam int NV = 26;
   localparam logic [20:0] VEC [NV] = '{
      {4'd9,  1'b1, OP_WR,   3'd0, 4'hC, 4'hC, RS_NONE},  // R9 accepted
      {4'd3,  1'b1, OP_WR,   3'd0, 4'h9, 4'h9, RS_ABRT},  // R3
      {4'd9,  1'b1, OP_WR,   3'd1, 4'hC, 4'hC, RS_NONE},
      {4'd4,  1'b1, OP_LD,   3'd1, 4'h0, 4'hC, RS_NONE},
      {4'd4,  1'b1, OP_WR,   3'd1, 4'h9, 4'hC, RS_NONE},  // R4 blocked
      {4'd5,  1'b1, OP_ARB,  3'd1, 4'h0, 4'h9, RS_ABRT},  // R5
      {4'd9,  1'b1, OP_WR,   3'd2, 4'hC, 4'hC, RS_NONE},
      {4'd4,  1'b1, OP_LD,   3'd2, 4'h0, 4'hC, RS_NONE},
      {4'd4,  1'b1, OP_WR,   3'd2, 4'h9, 4'hC, RS_NONE},
      {4'd6,  1'b1, OP_ERR,  3'd2, 4'h0, 4'h9, RS_ABRT},  // R6
      {4'd9,  1'b1, OP_WR,   3'd3, 4'hC, 4'hC, RS_NONE},
      {4'd4,  1'b1, OP_LD,   3'd3, 4'h0, 4'hC, RS_NONE},
      {4'd4,  1'b1, OP_WR,   3'd3, 4'h9, 4'hC, RS_NONE},
      {4'd7,  1'b1, OP_DONE, 3'd3, 4'h0, 4'h8, RS_SENT},  // R7 cancel dropped
      {4'd9,  1'b1, OP_WR,   3'd4, 4'hC, 4'hC, RS_NONE},
      {4'd8,  1'b1, OP_LD,   3'd4, 4'h0, 4'hC, RS_NONE},
      {4'd8,  1'b1, OP_ARB,  3'd4, 4'h0, 4'hC, RS_NONE},  // R8
      {4'd9,  1'b1, OP_WR,   3'd4, 4'h8, 4'hC, RS_NONE},  // R9 ignored
      {4'd8,  1'b1, OP_LD,   3'd4, 4'h0, 4'hC, RS_NONE},
      {4'd7,  1'b1, OP_DONE, 3'd4, 4'h0, 4'h8, RS_SENT},  // R7
      {4'd10, 1'b1, OP_WR,   3'd5, 4'h9, 4'h8, RS_NONE},  // R10
      {4'd1,  1'b0, OP_WR,   3'd6, 4'hC, 4'hC, RS_NONE},
      {4'd1,  1'b0, OP_LD,   3'd6, 4'h0, 4'hC, RS_NONE},
      {4'd1,  1'b0, OP_WR,   3'd6, 4'h9, 4'h9, RS_NONE},  // R1 busy mailbox written
      {4'd7,  1'b0, OP_DONE, 3'd6, 4'h0, 4'h8, RS_SENT},
      {4'd9,  1'b1, OP_WR,   3'd0, 4'h5, 4'h5, RS_NONE}   // R9 inactive-like accepted
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] code_of(input int m);
      return mb_code[m*4 +: 4];
   endfunction

   task automatic idle_inputs();
      wr_valid = 1'b0; load_valid = 1'b0;
      arb_lost = 1'b0; tx_done = 1'b0; tx_err = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(8 * 20000);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2 reset state
      for (int m = 0; m < 8; m++)
         chk(code_of(m) == 4'h8, "R2 reset code", code_of(m), 8);
      chk(mb_flag == 8'h00, "R2 reset flags", mb_flag, 0);
      chk(!res_valid, "R2 reset result", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         logic [20:0] e;
         string tag;
         e = VEC[v];
         tag = $sformatf("R%0d row %0d", e[20:17], v);
         abort_en = e[16];
         case (e[15:13])
            OP_WR:   begin wr_valid = 1'b1; wr_mb = e[12:10]; wr_code = e[9:6]; end
            OP_LD:   begin load_valid = 1'b1; load_mb = e[12:10]; end
            OP_ARB:  arb_lost = 1'b1;
            OP_DONE: tx_done = 1'b1;
            default: tx_err = 1'b1;
         endcase
         @(negedge clk);
         idle_inputs();
         chk(code_of(int'(e[12:10])) == e[5:2], {tag, " code"}, code_of(int'(e[12:10])), e[5:2]);
         case (e[1:0])
            RS_NONE: chk(!res_valid, {tag, " no result"}, res_valid, 0);
            RS_SENT: chk(res_valid && !res_aborted && res_mb == e[12:10], {tag, " sent result"},
                         {res_valid, res_aborted, res_mb}, {1'b1, 1'b0, e[12:10]});
            default: chk(res_valid && res_aborted && res_mb == e[12:10], {tag, " abort result"},
                         {res_valid, res_aborted, res_mb}, {1'b1, 1'b1, e[12:10]});
         endcase
      end
      abort_en = 1'b1;

      // R9 accepted write cleared mb0 flag; R5 set mb1 flag; R10 left mb5 flag clear
      chk(mb_flag[0] == 1'b0, "R9 flag cleared", mb_flag[0], 0);
      chk(mb_flag[1] == 1'b1, "R5 flag set", mb_flag[1], 1);
      chk(mb_flag[5] == 1'b0, "R10 flag untouched", mb_flag[5], 0);

      // R11 collision: immediate cancel of mb3 and send of mb7 on one edge
      wr_valid = 1'b1; wr_mb = 3'd3; wr_code = 4'hC; @(negedge clk);
      wr_mb = 3'd7; @(negedge clk);
      wr_valid = 1'b0; load_valid = 1'b1; load_mb = 3'd7; @(negedge clk);
      load_valid = 1'b0;
      wr_valid = 1'b1; wr_mb = 3'd3; wr_code = 4'h9; tx_done = 1'b1;
      @(negedge clk);
      idle_inputs();
      chk(res_valid && res_mb == 3'd3 && res_aborted, "R11 first result mb3",
          {res_valid, res_mb, res_aborted}, {1'b1, 3'd3, 1'b1});
      @(negedge clk);
      chk(res_valid && res_mb == 3'd7 && !res_aborted, "R11 second result mb7",
          {res_valid, res_mb, res_aborted}, {1'b1, 3'd7, 1'b0});
      @(negedge clk);
      chk(!res_valid, "R11 drained", res_valid, 0);

      // R5 cancel written in the same cycle as the arbitration loss
      wr_valid = 1'b1; wr_mb = 3'd6; wr_code = 4'hC; @(negedge clk);
      wr_valid = 1'b0; load_valid = 1'b1; load_mb = 3'd6; @(negedge clk);
      load_valid = 1'b0;
      wr_valid = 1'b1; wr_mb = 3'd6; wr_code = 4'h9; arb_lost = 1'b1;
      @(negedge clk);
      idle_inputs();
      chk(code_of(6) == 4'h9, "R5 same-cycle code", code_of(6), 9);
      chk(res_valid && res_mb == 3'd6 && res_aborted, "R5 same-cycle result",
          {res_valid, res_mb, res_aborted}, {1'b1, 3'd6, 1'b1});
      chk(mb_flag[6] == 1'b1, "R5 same-cycle flag", mb_flag[6], 1);

      // R2 reset in the middle clears state again
      rst_n = 1'b0; @(negedge clk);
      chk(mb_code == {8{4'h8}} && mb_flag == 8'h00, "R2 mid reset", mb_code, 32'h88888888);
      rst_n = 1'b1; @(negedge clk);
      finish_run();
   end
endmodule